// File: doc/BRIEF.md
# Modem Control and Status with Loopback

This block holds the modem control byte and the modem status byte of a 16550-style serial port. The control byte drives four handshake outputs (data terminal ready, request to send and two general-purpose outputs) and a loopback select. The status byte has two halves. The upper half shows the present level of the four handshake inputs: clear to send, data set ready, ring indicator and carrier detect. The lower half holds sticky change flags, which clear when software reads the status byte.

Each external handshake input passes through a synchroniser before any edge is detected. A change flag that is set raises a modem-status interrupt request. An interrupt controller elsewhere in the port assigns that request its priority.

Loopback is for self-test. When it is on, the external output pins go inactive and the external inputs are ignored. The control bits then feed the status inputs in a fixed crossed order. The block also steers the serial bit path: the transmit shifter's output goes straight to the receive shifter, and the serial output pin is held high.

Top module: `modem_ctl_status`

## Requirements
- R1: After reset the control byte reads 0. A write pulse loads bits 4..0 from the write data on the next edge. Bits 7..5 of the control read-back are always 0.
- R2: With loopback off (control bit 4 = 0), the output pins follow the control byte: bit 0 drives dtr_o, bit 1 drives rts_o, bit 2 drives out1_o and bit 3 drives out2_o.
- R3: With loopback on (control bit 4 = 1), dtr_o, rts_o, out1_o and out2_o are all 0, whatever the control byte holds.
- R4: With loopback off, status bits 7..4 show {dcd_i, ri_i, dsr_i, cts_i}. Each input passes through two flops and one level register, so a pin change shows in the status byte after the third rising edge.
- R5: Status bit 0 (clear to send), bit 1 (data set ready) and bit 3 (carrier detect) are change flags. Each one sets in the same cycle that its level bit in 7..4 changes, whether the level rises or falls.
- R6: Status bit 2 sets only when the ring indicator level in bit 6 falls from 1 to 0. A rise of that level leaves bit 2 unchanged.
- R7: A read pulse clears status bits 3..0 on the next edge. If a change occurs on that same edge, its flag stays set.
- R8: stat_irq is 1 exactly when any of status bits 3..0 is 1.
- R9: With loopback on, status bit 4 shows control bit 1, bit 5 shows bit 0, bit 6 shows bit 2 and bit 7 shows bit 3, one edge after the control byte changes. The external handshake inputs have no effect.
- R10: With loopback off, sout_o follows tx_bit_i and rx_bit_o follows sin_i. With loopback on, sout_o is 1, rx_bit_o follows tx_bit_i and sin_i is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_wr | input | 1 | Write pulse for the control byte |
| ctl_wdata | input | 5 | Write data for the control byte |
| ctl_rdata | output | 8 | Control byte read-back |
| stat_rd | input | 1 | Read pulse for the status byte; clears the change flags |
| stat_rdata | output | 8 | Status byte |
| stat_irq | output | 1 | Modem-status interrupt request |
| cts_i | input | 1 | Clear to send input |
| dsr_i | input | 1 | Data set ready input |
| ri_i | input | 1 | Ring indicator input |
| dcd_i | input | 1 | Carrier detect input |
| dtr_o | output | 1 | Data terminal ready output |
| rts_o | output | 1 | Request to send output |
| out1_o | output | 1 | General-purpose output 1 |
| out2_o | output | 1 | General-purpose output 2 |
| loop_o | output | 1 | Loopback select for the serial path |
| tx_bit_i | input | 1 | Bit from the transmit shifter |
| rx_bit_o | output | 1 | Bit to the receive shifter |
| sin_i | input | 1 | External serial input pin |
| sout_o | output | 1 | External serial output pin |

## Verification
The handshake inputs are driven in several patterns: one pin at a time, several pins together, and ring-indicator pulses in both directions. These patterns separate a crossed bit order, a missing synchroniser stage and a ring flag that fires on the wrong edge. Status reads are issued in three situations: with no change in flight, on the same edge as a change, and while the pins are steady. These separate a lost event from a flag that fails to clear. Loopback is exercised with several control bytes while the external pins toggle and the serial input swings. This shows the crossed mapping and the isolation of the external pins.

// File: rtl/modem_ctl_status.sv
module modem_ctl_status #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic [4:0] ctl_wdata,
  output logic [7:0] ctl_rdata,
  input  logic       stat_rd,
  output logic [7:0] stat_rdata,
  output logic       stat_irq,
  input  logic       cts_i,
  input  logic       dsr_i,
  input  logic       ri_i,
  input  logic       dcd_i,
  output logic       dtr_o,
  output logic       rts_o,
  output logic       out1_o,
  output logic       out2_o,
  output logic       loop_o,
  input  logic       tx_bit_i,
  output logic       rx_bit_o,
  input  logic       sin_i,
  output logic       sout_o
);

  logic [4:0] ctl;
  logic [3:0] sync_q [SYNC_STAGES];
  logic [3:0] lvl_q, delta_q, src, chg;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      ctl <= '0;
    else if (ctl_wr) ctl <= ctl_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
    end else begin
      sync_q[0] <= {dcd_i, ri_i, dsr_i, cts_i};
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end

  assign loop_o = ctl[4];
  // status order within a nibble: {dcd, ri, dsr, cts}
  assign src = loop_o ? {ctl[3], ctl[2], ctl[0], ctl[1]} : sync_q[SYNC_STAGES-1];
  assign chg = {src[3] ^ lvl_q[3], lvl_q[2] & ~src[2], src[1:0] ^ lvl_q[1:0]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lvl_q   <= '0;
      delta_q <= '0;
    end else begin
      lvl_q   <= src;
      delta_q <= (stat_rd ? 4'b0 : delta_q) | chg;
    end

  assign ctl_rdata  = {3'b000, ctl};
  assign stat_rdata = {lvl_q, delta_q};
  assign stat_irq   = |delta_q;

  assign dtr_o  = ctl[0] & ~loop_o;
  assign rts_o  = ctl[1] & ~loop_o;
  assign out1_o = ctl[2] & ~loop_o;
  assign out2_o = ctl[3] & ~loop_o;

  assign sout_o   = loop_o ? 1'b1 : tx_bit_i;
  assign rx_bit_o = loop_o ? tx_bit_i : sin_i;

  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && src == lvl_q) |=> stat_rdata[3:0] == 4'b0);

  a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_rd && stat_rdata[0]) |=> stat_rdata[0]);

  a_r6_ri_trailing: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_rdata[2]) |-> ($past(stat_rdata[6]) && !stat_rdata[6]));

  a_r8_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_rd && stat_irq) |=> stat_irq);

  a_r3_pins_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ctl_wr) && $past(ctl_wdata[4])) |-> !(dtr_o | rts_o | out1_o | out2_o));

  a_r10_sout_idle: assert property (@(posedge clk) disable iff (!rst_n)
    loop_o |-> sout_o);

endmodule

// File: tb/test_modem_ctl_status.sv
module test_modem_ctl_status;
  logic clk = 0, rst_n = 0;
  logic ctl_wr = 0, stat_rd = 0;
  logic [4:0] ctl_wdata = 0;
  logic cts = 0, dsr = 0, ri = 0, dcd = 0, txb = 0, sin = 0;
  logic [7:0] ctl_rdata, stat_rdata;
  logic stat_irq, dtr, rts, out1, out2, loopo, rxb, sout;

  int checks = 0, fails = 0;
  bit done = 0;

  modem_ctl_status i_modem_ctl_status (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .stat_rd(stat_rd), .stat_rdata(stat_rdata),
    .stat_irq(stat_irq), .cts_i(cts), .dsr_i(dsr), .ri_i(ri), .dcd_i(dcd),
    .dtr_o(dtr), .rts_o(rts), .out1_o(out1), .out2_o(out2), .loop_o(loopo),
    .tx_bit_i(txb), .rx_bit_o(rxb), .sin_i(sin), .sout_o(sout));

  always #10 clk = ~clk;

  // reference model: pin history queue, control, levels, flags
  logic [3:0] pin_q[$];
  logic [4:0] m_ctl = 0;
  logic [3:0] m_lvl = 0, m_flag = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      pin_q = {4'h0, 4'h0};
      m_ctl = 0; m_lvl = 0; m_flag = 0;
    end else begin
      logic [3:0] nxt;
      nxt = m_ctl[4] ? {m_ctl[3], m_ctl[2], m_ctl[0], m_ctl[1]} : pin_q[0];
      if (stat_rd) m_flag = 0;
      if (nxt[0] != m_lvl[0]) m_flag[0] = 1;
      if (nxt[1] != m_lvl[1]) m_flag[1] = 1;
      if (m_lvl[2] && !nxt[2]) m_flag[2] = 1;
      if (nxt[3] != m_lvl[3]) m_flag[3] = 1;
      m_lvl = nxt;
      void'(pin_q.pop_front());
      pin_q.push_back({dcd, ri, dsr, cts});
      if (ctl_wr) m_ctl = ctl_wdata;
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (!done) begin
    logic lp;
    lp = m_ctl[4];
    chk("R1 control read-back", ctl_rdata, {3'b0, m_ctl});
    chk(lp ? "R3 pins in loopback" : "R2 pins follow control",
        {4'b0, out2, out1, rts, dtr}, lp ? 8'h0 : {4'b0, m_ctl[3:0]});
    chk(lp ? "R9 loopback levels" : "R4 synchronised levels",
        {4'b0, stat_rdata[7:4]}, {4'b0, m_lvl});
    chk("R5 R6 R7 change flags", {4'b0, stat_rdata[3:0]}, {4'b0, m_flag});
    chk("R8 interrupt request", {7'b0, stat_irq}, {7'b0, |m_flag});
    chk("R10 serial path", {6'b0, sout, rxb},
        lp ? {6'b0, 1'b1, txb} : {6'b0, txb, sin});
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [4:0] d);
    ctl_wdata = d; ctl_wr = 1; tick(); ctl_wr = 0;
  endtask

  task automatic rd();
    stat_rd = 1; tick(); stat_rd = 0;
  endtask

  initial begin
    #100000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1;
    tick(2);
    // R1 R2: control writes
    wr(5'h0F); tick(2);
    wr(5'h05); tick(); wr(5'h0A); tick(2);
    // R4 R5: single pins, both edges
    cts = 1; tick(5); dsr = 1; tick(5); dcd = 1; tick(5);
    rd(); tick(3);
    cts = 0; tick(5); rd(); tick(2);
    // R6: ring rise then fall
    ri = 1; tick(5); ri = 0; tick(5); rd(); tick(2);
    // several pins together, short ring pulse
    {dcd, ri, dsr, cts} = 4'b0101; tick(); ri = 1; tick(); ri = 0; tick(5);
    // R7: read on the same edge as a change reaching the level register
    rd(); tick(2);
    dsr = 1; tick(2); stat_rd = 1; tick(); stat_rd = 0; tick(3);
    rd(); tick(3);
    // R10 serial outside loopback
    repeat (4) begin txb = ~txb; tick(); sin = ~sin; tick(); end
    // R3 R9: loopback, pins toggling ignored
    wr(5'h10); tick(3); rd(); tick(2);
    wr(5'h11); tick(3); wr(5'h12); tick(3); wr(5'h14); tick(3);
    wr(5'h10); tick(3); wr(5'h18); tick(3); wr(5'h1F); tick(3);
    repeat (6) begin {dcd, ri, dsr, cts} = ~{dcd, ri, dsr, cts}; sin = ~sin; txb = ~txb; tick(); end
    rd(); tick(3);
    wr(5'h0C); tick(6); rd(); tick(4);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule